// File: doc/BRIEF.md
# Interrupt Source Gateway Bank

This block sits between raw interrupt lines coming from peripherals and the arbitration logic of an interrupt controller. It holds one gateway per source and turns each raw line into a single pending bit. A per-source mode input chooses how an event is recognised: a rising transition of the line, or the line simply being high. The arbiter and the claim/complete register logic stay outside the block. They hand the block one claim pulse and one complete pulse per source and read back the vector of pending bits.

Each gateway is a three-state machine. In ARMED it waits for an event. PENDING holds the pending bit high. IN_SERVICE covers the time after a claim and before completion. The transitions are:
- ARMED to PENDING when an event is seen and no claim arrives in the same cycle.
- PENDING to IN_SERVICE on a claim.
- IN_SERVICE to ARMED on a complete.

While a gateway is in PENDING or IN_SERVICE it drops every event. Missed edges are not counted or queued, and a level line that falls does not withdraw a pending bit. Source 0 stands for "no interrupt", so its gateway never leaves ARMED.

Top module: `irq_gateway_bank`

## Requirements
- R1: After reset every bit of `pending_o` is 0, and each edge detector's stored previous input is 0.
- R2: A source with `edge_mode_i` bit = 0 (level mode) whose input is 1 while its gateway is armed shows `pending_o` = 1 after the next rising clock edge.
- R3: A source with `edge_mode_i` bit = 1 (edge mode) becomes pending only on a 0-to-1 change of its input between consecutive clock edges. An input held at 1 sets nothing further.
- R4: Once set, a pending bit stays 1 until a claim, even if a level input falls back to 0.
- R5: A claim pulse on a pending source clears its `pending_o` bit after the next clock edge, whatever the input value.
- R6: From the cycle a pending bit sets until completion, all new events for that source are dropped. An edge seen in that window does not produce a pending bit after completion.
- R7: A complete pulse on an in-service source re-arms it in that clock edge. A level input that is still high, or high again, sets `pending_o` one clock edge later.
- R8: A complete pulse for a source that is not in service (armed or pending) has no effect.
- R9: When a claim and an event for an armed source arrive in the same cycle, the claim wins and the event is dropped.
- R10: `pending_o[0]` is always 0, whatever `src_i[0]`, claim or complete do.
- R11: Sources are independent. A claim or complete for one source does not change the pending bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Raw interrupt lines; bit i is source ID i |
| edge_mode_i | input | N_SRC | 1 = edge detection, 0 = level detection, per source |
| claim_i | input | N_SRC | One-cycle claim pulse per source |
| complete_i | input | N_SRC | One-cycle completion pulse per source |
| pending_o | output | N_SRC | Pending bit per source |

## Verification
Level sources are driven high, dropped and raised again across claim and completion. This separates simple input following from a latched pending bit, and shows when re-arming takes effect. Edge sources are given held-high inputs, fresh rising edges and edges inside the in-service window, which tells a true edge detector apart from level sensing and from edge queuing. Claims that coincide with events, completes sent to gateways that are not in service, activity on source 0, and two level sources claimed one at a time cover priority, the no-op case, the tied-off ID and cross-source isolation.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    typedef enum logic [1:0] {
        GW_ARMED      = 2'b00,
        GW_PENDING    = 2'b01,
        GW_IN_SERVICE = 2'b10
    } gw_state_e;

endpackage

// File: rtl/irq_gw_event_det.sv
module irq_gw_event_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic edge_mode_i,
    output logic event_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_i;
        end
    end

    always_comb begin
        if (edge_mode_i) begin
            event_o = line_i & ~prev_q;
        end else begin
            event_o = line_i;
        end
    end

    // R3: in edge mode an event needs the line low on the previous edge
    p_edge_needs_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && prev_q) |-> !event_o);

endmodule

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
    import irq_gw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic event_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    gw_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GW_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_ARMED: begin
                if (claim_i) begin
                    state_d = GW_ARMED;
                end else if (event_i) begin
                    state_d = GW_PENDING;
                end
            end
            GW_PENDING: begin
                if (claim_i) begin
                    state_d = GW_IN_SERVICE;
                end
            end
            GW_IN_SERVICE: begin
                if (complete_i) begin
                    state_d = GW_ARMED;
                end
            end
            default: begin
                state_d = GW_ARMED;
            end
        endcase
    end

    always_comb begin
        pending_o = (state_q == GW_PENDING);
    end

    // R5: a claim always leaves the pending bit low
    p_claim_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_i |=> !pending_o);

    // R4: pending holds until claimed
    p_pending_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && !claim_i) |=> pending_o);

    // R6: no pending bit while awaiting completion
    p_locked_in_service_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GW_IN_SERVICE) |=> !pending_o);

    // R9: a claim on an armed gateway drops a simultaneous event
    p_claim_beats_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GW_ARMED && claim_i) |=> (state_q == GW_ARMED));

    // R8: complete to a pending gateway keeps it pending
    p_complete_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && complete_i && !claim_i) |=> pending_o);

endmodule

// File: rtl/irq_gateway_bank.sv
module irq_gateway_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] edge_mode_i,
    input  logic [N_SRC-1:0] claim_i,
    input  logic [N_SRC-1:0] complete_i,
    output logic [N_SRC-1:0] pending_o
);

    localparam logic [N_SRC-1:0] RESERVED_MASK = {{(N_SRC-1){1'b0}}, 1'b1};

    logic [N_SRC-1:0] line_gated;
    logic [N_SRC-1:0] event_w;

    assign line_gated = src_i & ~RESERVED_MASK;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_gw_event_det u_det (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .line_i      (line_gated[g]),
            .edge_mode_i (edge_mode_i[g]),
            .event_o     (event_w[g])
        );

        irq_gw_cell u_cell (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .event_i    (event_w[g]),
            .claim_i    (claim_i[g]),
            .complete_i (complete_i[g]),
            .pending_o  (pending_o[g])
        );
    end

    // R10: the reserved ID never becomes pending
    p_reserved_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> !pending_o[0]);

    // R2: an armed level source that is high and not claimed becomes pending
    for (genvar h = 1; h < N_SRC; h++) begin : g_chk
        p_level_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!edge_mode_i[h] && src_i[h] && !claim_i[h] && !pending_o[h]
             && $past(complete_i[h]) && $past(!pending_o[h]) && !$past(claim_i[h]))
            |=> pending_o[h]);
    end

endmodule

// File: tb/irq_gateway_bank_tb_top.sv
module irq_gateway_bank_tb_top;

    localparam int N = 8;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } sb_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [N-1:0] mode = 8'b0001_0100;
    logic [N-1:0] claim = '0;
    logic [N-1:0] cmpl = '0;
    logic [N-1:0] pend;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_gateway_bank #(.N_SRC(N)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .edge_mode_i (mode),
        .claim_i     (claim),
        .complete_i  (cmpl),
        .pending_o   (pend)
    );

    task automatic step(input logic [N-1:0] s, input logic [N-1:0] c,
                        input logic [N-1:0] k, input logic [N-1:0] e,
                        input string tag);
        sb_item_t it;
        @(negedge clk);
        src = s;
        claim = c;
        cmpl = k;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (pend !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pending_o=%b expected=%b", it.tag, pend, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        #1;
        checks++;
        if (pend !== '0) begin
            errors++;
            $display("FAIL R1: pending_o=%b expected=%b during reset", pend, 8'h00);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h00, 8'h00, 8'h00, 8'h00, "R1 idle after reset");
        // level source 1
        step(8'h02, 8'h00, 8'h00, 8'h02, "R2 level sets");
        step(8'h00, 8'h00, 8'h00, 8'h02, "R4 level drop keeps pending");
        step(8'h02, 8'h02, 8'h00, 8'h00, "R5 claim with line high");
        step(8'h02, 8'h00, 8'h00, 8'h00, "R6 level ignored in service");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R6 in service");
        step(8'h02, 8'h00, 8'h00, 8'h00, "R6 new level ignored");
        step(8'h02, 8'h00, 8'h02, 8'h00, "R7 complete cycle");
        step(8'h02, 8'h00, 8'h00, 8'h02, "R7 rearm sets next cycle");
        step(8'h00, 8'h02, 8'h00, 8'h00, "R5 claim with line low");
        step(8'h00, 8'h00, 8'h02, 8'h00, "R7 complete with line low");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R7 low line stays armed");
        // edge source 2
        step(8'h04, 8'h00, 8'h00, 8'h04, "R3 rising edge sets");
        step(8'h04, 8'h04, 8'h00, 8'h00, "R5 claim edge source");
        step(8'h04, 8'h00, 8'h04, 8'h00, "R7 complete edge source");
        step(8'h04, 8'h00, 8'h00, 8'h00, "R3 held high no event");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R3 drop");
        step(8'h04, 8'h00, 8'h00, 8'h04, "R3 second rise");
        step(8'h00, 8'h00, 8'h00, 8'h04, "R4 edge pending holds");
        step(8'h04, 8'h00, 8'h00, 8'h04, "R6 edge while pending");
        step(8'h00, 8'h04, 8'h00, 8'h00, "R5 claim");
        step(8'h04, 8'h00, 8'h00, 8'h00, "R6 edge in service ignored");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R6 in service");
        step(8'h00, 8'h00, 8'h04, 8'h00, "R6 complete");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R6 no queued edge");
        // edge source 4, complete when not in service
        step(8'h00, 8'h00, 8'h10, 8'h00, "R8 complete while armed");
        step(8'h10, 8'h00, 8'h00, 8'h10, "R8 edge after stray complete");
        step(8'h10, 8'h00, 8'h10, 8'h10, "R8 complete while pending");
        step(8'h00, 8'h10, 8'h00, 8'h00, "R5 claim src4");
        step(8'h10, 8'h00, 8'h00, 8'h00, "R8 still in service");
        step(8'h10, 8'h00, 8'h10, 8'h00, "R7 complete src4");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R7 low");
        // claim and event together
        step(8'h10, 8'h10, 8'h00, 8'h00, "R9 edge dropped by claim");
        step(8'h10, 8'h00, 8'h00, 8'h00, "R9 no later edge");
        step(8'h18, 8'h08, 8'h00, 8'h00, "R9 level dropped by claim");
        step(8'h18, 8'h00, 8'h00, 8'h08, "R9 level sets next cycle");
        step(8'h00, 8'h08, 8'h00, 8'h00, "R5 claim src3");
        step(8'h00, 8'h00, 8'h08, 8'h00, "R7 complete src3");
        // reserved source 0
        step(8'h01, 8'h00, 8'h00, 8'h00, "R10 src0 high");
        step(8'h01, 8'h01, 8'h01, 8'h00, "R10 src0 claim complete");
        step(8'h00, 8'h00, 8'h00, 8'h00, "R10 src0 low");
        // independence
        step(8'h0A, 8'h00, 8'h00, 8'h0A, "R11 two sources pending");
        step(8'h0A, 8'h02, 8'h00, 8'h08, "R11 claim one only");
        step(8'h0A, 8'h00, 8'h02, 8'h08, "R11 complete one only");
        step(8'h0A, 8'h00, 8'h00, 8'h0A, "R11 rearmed one only");
        step(8'h00, 8'h00, 8'h00, 8'h0A, "R11 both hold");
        @(negedge clk);
        src = '0;
        claim = '0;
        cmpl = '0;
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule